// File: doc/BRIEF.md
# DMA Completion Response Queue

This block holds one record per finished DMA descriptor until the host has consumed it. Each record carries the byte count that the data mover reports and a status word that packs an 8-bit error field with an early-termination flag. The data mover pushes records over a valid/ready interface. When the queue is full, ready drops and the mover stalls, so no record is lost.

The host reads records through a two-word register window. The byte-count word sits at byte offset 0x00 and the status word at byte offset 0x04. Reading the byte-count word has no side effect, so it can be read as often as needed. Reading the status word retires the head record. A host that reads the count word and then the status word therefore consumes exactly one record.

The block also drives a 32-bit fill-level word, with the number of queued records in its low half, and separate empty and full flags for a neighbouring control/status block. A synchronous flush input discards every queued record.

Top module: `dma_resp_queue`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `push_ready_o`=1, and `fill_level_o`=0.
- R2: Records leave in the order they were accepted. A read of offset 0x00 returns the head record's byte count. A read of offset 0x04 returns the status word: bits 7:0 hold the error field, bit 8 holds the early-termination flag, and bits 31:9 are zero.
- R3: A read of offset 0x00 leaves the queue unchanged. The fill level stays the same, and repeated reads return the same value.
- R4: A read of offset 0x04 while the queue is not empty retires the head record. The fill level drops by one in the cycle after the read.
- R5: Read data appears on `rd_data_o` in the cycle after the cycle in which `rd_en_i` is sampled high.
- R6: A read of either offset while the queue is empty returns zero. The fill level stays at zero, and later pushes and reads behave normally.
- R7: When DEPTH records are queued, `full_o`=1 and `push_ready_o`=0. A push offered in that state is not stored, and no queued record is overwritten.
- R8: `fill_level_o[15:0]` equals the number of queued records, saturated at 0xFFFF. `fill_level_o[31:16]` is zero.
- R9: A cycle with `flush_i` high empties the queue, even if a push or a retiring read occurs in the same cycle.
- R10: An accepted push and a retiring read in the same cycle leave the fill level unchanged. The pushed record joins the tail of the queue.
- R11: A read of any offset other than 0x00 and 0x04 returns zero and retires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all queued records |
| push_valid_i | input | 1 | Producer offers a record |
| push_ready_o | output | 1 | Queue can accept a record |
| push_bytes_i | input | BYTES_W | Bytes transferred for the finished descriptor |
| push_err_i | input | 8 | Error bits of the finished descriptor |
| push_early_i | input | 1 | Descriptor ended early |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | ADDR_W | Byte offset within the window |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| fill_level_o | output | 32 | Queued record count in bits 15:0 |
| empty_o | output | 1 | No record queued |
| full_o | output | 1 | DEPTH records queued |

## Verification
The bench runs with a depth that is not a power of two and fills the queue to every level from one up to full, across several rounds so that both pointers wrap. Each wrap would expose a pointer that returns to zero at the wrong place: records would come back in the wrong order or as stale data.

Each round does the following:
- It reads the count word twice before the status word. A design that retires on the count read would skip every second record.
- It offers a push while the queue is full. A design that ignored ready would overwrite the oldest entry.
- It reads the queue while empty. Underflowing pointers would produce a fill level near 0xFFFF and garbage on later reads.
- It combines a push with a retire, and a flush with a push in the same cycle. A design that got the priority wrong would leave the level off by one.

// File: rtl/dmaresp_pkg.sv
package dmaresp_pkg;
   localparam int ERR_W      = 8;
   localparam int WORD_W     = 32;
   localparam int LVL_W      = 16;
   localparam int OFF_BYTES  = 0;
   localparam int OFF_STATUS = 4;

   typedef struct packed {
      logic              early;
      logic [ERR_W-1:0]  err;
      logic [WORD_W-1:0] nbytes;
   } resp_t;

   function automatic logic [WORD_W-1:0] status_word(input resp_t r);
      return {{(WORD_W-ERR_W-1){1'b0}}, r.early, r.err};
   endfunction
endpackage

// File: rtl/resp_store.sv
module resp_store
   import dmaresp_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_valid_i,
   input  resp_t            push_data_i,
   output logic             push_ready_o,
   input  logic             pop_i,
   output resp_t            head_o,
   output logic [CNT_W-1:0] count_o,
   output logic             empty_o,
   output logic             full_o
);
   resp_t            mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             push_fire;

   assign full_o       = (count == CNT_W'(DEPTH));
   assign empty_o      = (count == '0);
   assign push_ready_o = !full_o;
   assign push_fire    = push_valid_i && push_ready_o;
   assign head_o       = mem[rd_ptr];
   assign count_o      = count;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_fire && !flush_i) mem[wr_ptr] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_fire) wr_ptr <= wr_nxt;
         if (pop_i)     rd_ptr <= rd_nxt;
         case ({push_fire, pop_i})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R4
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_fire && !flush_i) |=> count == CNT_W'($past(count) - 1'b1));
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> count != '0);
   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !pop_i && !flush_i) |=> full_o);
   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (count == '0));
   // R10
   pushpop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && push_fire && !flush_i) |=> count == $past(count));
endmodule

// File: rtl/resp_level.sv
module resp_level
   import dmaresp_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0]  count_i,
   output logic [WORD_W-1:0] level_o
);
   logic [LVL_W-1:0] lvl;

   generate
      if (CNT_W > LVL_W) begin : g_saturate
         localparam logic [CNT_W-1:0] SAT = CNT_W'((1 << LVL_W) - 1);
         assign lvl = (count_i > SAT) ? '1 : count_i[LVL_W-1:0];
      end else begin : g_extend
         assign lvl = LVL_W'(count_i);
      end
   endgenerate

   assign level_o = WORD_W'(lvl);
endmodule

// File: rtl/resp_window.sv
module resp_window
   import dmaresp_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  resp_t             head_i,
   input  logic              empty_i,
   output logic              pop_o,
   output logic [WORD_W-1:0] rd_data_o
);
   logic              hit_bytes, hit_status;
   logic [WORD_W-1:0] rd_nxt;

   assign hit_bytes  = (rd_addr_i == ADDR_W'(OFF_BYTES));
   assign hit_status = (rd_addr_i == ADDR_W'(OFF_STATUS));
   assign pop_o      = rd_en_i && hit_status && !empty_i;

   always_comb begin
      rd_nxt = '0;
      if (!empty_i) begin
         if (hit_bytes)       rd_nxt = head_i.nbytes;
         else if (hit_status) rd_nxt = status_word(head_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_nxt;
   end

   // R6
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && empty_i) |=> rd_data_o == '0);
   // R5
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/dma_resp_queue.sv
module dma_resp_queue
   import dmaresp_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int BYTES_W = 32,
   parameter int ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               push_valid_i,
   output logic               push_ready_o,
   input  logic [BYTES_W-1:0] push_bytes_i,
   input  logic [ERR_W-1:0]   push_err_i,
   input  logic               push_early_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [WORD_W-1:0]  rd_data_o,
   output logic [WORD_W-1:0]  fill_level_o,
   output logic               empty_o,
   output logic               full_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $fatal(1, "dma_resp_queue: DEPTH must be at least 2");
      end
      if (BYTES_W < 1 || BYTES_W > WORD_W) begin : g_bad_bytes
         initial $fatal(1, "dma_resp_queue: BYTES_W must be 1..32");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         initial $fatal(1, "dma_resp_queue: ADDR_W must reach offset 4");
      end
   endgenerate

   resp_t            push_rec, head;
   logic             pop;
   logic [CNT_W-1:0] count;

   assign push_rec.nbytes = WORD_W'(push_bytes_i);
   assign push_rec.err    = push_err_i;
   assign push_rec.early  = push_early_i;

   resp_store #(.DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .push_valid_i(push_valid_i), .push_data_i(push_rec),
      .push_ready_o(push_ready_o), .pop_i(pop), .head_o(head),
      .count_o(count), .empty_o(empty_o), .full_o(full_o)
   );

   resp_window #(.ADDR_W(ADDR_W)) window_i (
      .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
      .head_i(head), .empty_i(empty_o), .pop_o(pop), .rd_data_o(rd_data_o)
   );

   resp_level #(.CNT_W(CNT_W)) level_i (
      .count_i(count), .level_o(fill_level_o)
   );

   // R3
   bytes_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i == ADDR_W'(OFF_BYTES) && !push_valid_i && !flush_i)
      |=> $stable(fill_level_o));
   // R8
   level_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level_o[WORD_W-1:LVL_W] == '0);
endmodule

// File: tb/dma_resp_queue_tb_top.sv
module dma_resp_queue_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 5;

   logic        clk = 0, rst_n = 0, flush = 0;
   logic        push_valid = 0, push_early = 0, rd_en = 0;
   logic [31:0] push_bytes = 0;
   logic [7:0]  push_err = 0;
   logic [2:0]  rd_addr = 0;
   logic        push_ready, empty, full;
   logic [31:0] rd_data, level;

   int checks = 0, failures = 0;
   logic [31:0] m_bytes [0:255];
   logic [31:0] m_stat  [0:255];
   int mh = 0, mt = 0, seq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_resp_queue #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .push_valid_i(push_valid), .push_ready_o(push_ready),
      .push_bytes_i(push_bytes), .push_err_i(push_err), .push_early_i(push_early),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .fill_level_o(level), .empty_o(empty), .full_o(full)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_flags(input string req);
      int n = mt - mh;
      chk({req, " level"}, level, 32'(n));
      chk({req, " empty"}, {31'b0, empty}, {31'b0, n == 0});
      chk({req, " full"},  {31'b0, full},  {31'b0, n == DEPTH});
      chk({req, " ready"}, {31'b0, push_ready}, {31'b0, n != DEPTH});
   endtask

   function automatic logic [31:0] pat_bytes(input int i);
      return 32'(i) * 32'h0101_0103 + 32'd7;
   endfunction
   function automatic logic [7:0] pat_err(input int i);
      return 8'((i * 29 + 3) & 255);
   endfunction

   task automatic set_push(input int i);
      push_valid = 1;
      push_bytes = pat_bytes(i);
      push_err   = pat_err(i);
      push_early = (i % 3 == 0);
   endtask

   task automatic model_push(input int i);
      m_bytes[mt % 256] = pat_bytes(i);
      m_stat[mt % 256]  = {23'b0, (i % 3 == 0), pat_err(i)};
      mt++;
   endtask

   // R7: a push offered while full is dropped by the model too
   task automatic do_push();
      @(negedge clk);
      set_push(seq);
      if (mt - mh < DEPTH) model_push(seq);
      seq++;
      @(negedge clk);
      push_valid = 0;
   endtask

   task automatic do_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1; rd_addr = a;
      @(negedge clk);
      rd_en = 0;
      d = rd_data;
   endtask

   // R2 R3 R4 R5: count word twice, then status word retires
   task automatic read_record(input string tag);
      logic [31:0] d;
      do_read(3'd0, d);
      chk({tag, " R2 R5 bytes"}, d, m_bytes[mh % 256]);
      chk_flags({tag, " R3 no pop"});
      do_read(3'd0, d);
      chk({tag, " R3 bytes again"}, d, m_bytes[mh % 256]);
      do_read(3'd4, d);
      chk({tag, " R2 status"}, d, m_stat[mh % 256]);
      mh++;
      chk_flags({tag, " R4 pop"});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      rst_n = 1;
      // R1
      chk_flags("R1 reset");
      chk("R1 rd_data", rd_data, 32'h0);

      for (int round = 0; round < 3; round++) begin
         for (int k = 1; k <= DEPTH; k++) begin
            for (int j = 0; j < k; j++) begin
               do_push();
               chk_flags("R8 fill");
            end
            if (k == DEPTH) begin
               // R7
               do_push();
               chk_flags("R7 full push dropped");
            end
            // R11
            do_read(3'd2, d);
            chk("R11 other offset", d, 32'h0);
            chk_flags("R11 no pop");
            for (int j = 0; j < k; j++) read_record("R2 drain");
            // R6
            do_read(3'd4, d);
            chk("R6 empty status", d, 32'h0);
            do_read(3'd0, d);
            chk("R6 empty bytes", d, 32'h0);
            chk_flags("R6 no underflow");
         end
      end

      // R10: push and retire in the same cycle
      do_push();
      do_push();
      @(negedge clk);
      set_push(seq); rd_en = 1; rd_addr = 3'd4;
      @(negedge clk);
      push_valid = 0; rd_en = 0;
      chk("R10 status", rd_data, m_stat[mh % 256]);
      mh++; model_push(seq); seq++;
      chk_flags("R10 level kept");
      read_record("R10 order");
      read_record("R10 order");

      // R9: flush beats a same-cycle push
      do_push();
      do_push();
      @(negedge clk);
      set_push(seq); seq++; flush = 1;
      @(negedge clk);
      push_valid = 0; flush = 0;
      mh = mt;
      chk_flags("R9 flush");
      do_push();
      read_record("R9 after flush");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule